// File: doc/BRIEF.md
# Character LCD Power-On Initialization Sequencer

This block brings a character LCD controller from power-up into a known operating state. The controller's busy indicator cannot be trusted yet, so the block never polls it. It sends a fixed series of instruction writes, with a timed wait after each one. It hands each instruction byte, or each half of a byte, to a downstream bus-cycle engine through a request/acknowledge pair. The engine is responsible for the electrical strobe timing. The block only decides what to send and when.

A strap input picks either the full 8-bit data path or the 4-bit path. The strap is sampled while reset is held. In 4-bit mode the block first sends a lone opening nibble. Every later instruction then goes out as two nibbles, high half first. Parameters fix the line-count, font, display, cursor, blink, increment and shift bits. Every wait is counted in system clock cycles, derived from a clock-frequency parameter with one cycle of margin. When the last wait has elapsed, a ready output rises and stays high. Normal text writes can start from that point.

Top module: `lcd_init_seq`

## Requirements
- R1: After reset is released, the first request appears exactly P+1 rising edges later. P = ceil(40000 us x CLK_HZ / 1e6) + 1.
- R2: Once `busReq` is raised, it and `busData` stay unchanged until a rising edge at which `busAck` is also high; that edge completes the transfer.
- R3: In 8-bit mode the block sends exactly five bytes, in this order: function set `0011_N_F_00` (N = LINES2, F = FONT), the same function set again, display control `00001_D_C_B` (DISP_ON, CURSOR_ON, BLINK_ON), clear `00000001`, and entry mode `000001_I_S` (INCREMENT, SHIFT_ON).
- R4: In 4-bit mode each nibble is sent on `busData[7:4]`, with `busData[3:0]` at zero. The transfers are, in order: the lone nibble `0010`, then two function-set pairs `0010` / `N_F_00`, then the display control, clear and entry mode instructions, each as a pair.
- R5: In 4-bit mode the high nibble of an instruction goes out first. The low nibble is requested on the first edge after the high nibble is accepted, with no wait in between.
- R6: After each completed instruction (or after the lone nibble), the next request rises exactly G+1 edges after the completing edge. G = ceil(t x CLK_HZ / 1e6) + 1, where t is 39 us after a function set or the lone nibble, 37 us after display control, 1530 us after clear, and 39 us after entry mode.
- R7: `ready` stays low until G+1 edges after the entry mode transfer completes, then stays high; no request is made after that.
- R8: The mode strap is sampled only while reset is asserted (0 = 8-bit, 1 = 4-bit). Changing it afterwards does not change the transfers.
- R9: While reset is held, `busReq` and `ready` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset; also the strap sampling window |
| mode4 | input | 1 | Interface strap: 1 selects the 4-bit path, 0 the 8-bit path |
| busAck | input | 1 | Bus engine accepts the pending transfer at this edge |
| busReq | output | 1 | An instruction transfer is pending |
| busData | output | 8 | Instruction byte, or nibble on bits 7:4 in 4-bit mode |
| ready | output | 1 | Start-up sequence finished; display usable |

## Verification
A wrong step index or nibble phase in this block shows up at once on `busData`, on the very next request. The wrong code or nibble order appears there, or the transfer count at the end is off. A wrong delay-class choice or wrong counter reload does not change any data. It only moves the rising edge of the following request by a fixed number of cycles, so the bench measures every gap to the exact edge and not just against a lower limit. A mis-latched strap changes the first transfer, about 40001 cycles after reset at the bench's clock parameter. A sticky-ready fault shows only as an extra request or a falling `ready` after the sequence ends, so the bench watches the outputs for a while after completion.

// File: rtl/lcd_init_pkg.sv
package lcd_init_pkg;

  // Wait categories following a transfer
  typedef enum logic [1:0] {
    GAP_FSET  = 2'd0,
    GAP_DISP  = 2'd1,
    GAP_CLR   = 2'd2,
    GAP_ENTRY = 2'd3
  } gapKind_e;

  // One entry of the start-up program
  typedef struct packed {
    logic [7:0] code;
    logic       single;   // only the high nibble is sent (4-bit opening)
    gapKind_e   gap;
  } stepInfo_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadGap;
    logic nextNibble;
    logic nextStep;
  } seqStrobe_t;

  typedef enum logic [1:0] {
    ST_POWER = 2'd0,
    ST_REQ   = 2'd1,
    ST_GAP   = 2'd2,
    ST_DONE  = 2'd3
  } seqState_e;

  // Minimum waits in microseconds
  localparam int unsigned US_POWER = 40000;
  localparam int unsigned US_FSET  = 39;
  localparam int unsigned US_DISP  = 37;
  localparam int unsigned US_CLR   = 1530;
  localparam int unsigned US_ENTRY = 39;

  // Round the wait up to whole cycles, then add one cycle of margin
  function automatic int unsigned usToCycles(input longint unsigned us,
                                             input longint unsigned hz);
    longint unsigned t;
    t = (us * hz + 64'd999999) / 64'd1000000;
    return 32'(t + 64'd1);
  endfunction

endpackage

// File: rtl/lcd_init_dp.sv
module lcd_init_dp
  import lcd_init_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 100_000_000,
  parameter bit          LINES2    = 1'b1,
  parameter bit          FONT      = 1'b0,
  parameter bit          DISP_ON   = 1'b1,
  parameter bit          CURSOR_ON = 1'b0,
  parameter bit          BLINK_ON  = 1'b0,
  parameter bit          INCREMENT = 1'b1,
  parameter bit          SHIFT_ON  = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       mode4In,
  input  seqStrobe_t strobe,
  output logic       delayZero,
  output logic       lastStep,
  output logic       needLow,
  output logic [7:0] xferData
);

  localparam int unsigned PWR_CYC   = usToCycles(US_POWER, CLK_HZ);
  localparam int unsigned FSET_CYC  = usToCycles(US_FSET, CLK_HZ);
  localparam int unsigned DISP_CYC  = usToCycles(US_DISP, CLK_HZ);
  localparam int unsigned CLR_CYC   = usToCycles(US_CLR, CLK_HZ);
  localparam int unsigned ENTRY_CYC = usToCycles(US_ENTRY, CLK_HZ);
  localparam int unsigned CNT_W     = $clog2(PWR_CYC + 1);
  localparam int unsigned IDX_W     = 3;
  localparam logic [IDX_W-1:0] LAST8 = IDX_W'(4);
  localparam logic [IDX_W-1:0] LAST4 = IDX_W'(5);

  logic [IDX_W-1:0] stepIdx;
  logic             lowPhase;
  logic             mode4Reg;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] gapLoad;
  stepInfo_t        cur;

  // Start-up program: index and mode select the instruction
  function automatic stepInfo_t stepAt(input logic [IDX_W-1:0] idx, input logic m4);
    stepInfo_t s;
    logic [IDX_W-1:0] k;
    s = '{code: 8'h00, single: 1'b0, gap: GAP_FSET};
    if (m4 && idx == '0) begin
      s.code   = 8'b0010_0000;
      s.single = 1'b1;
      s.gap    = GAP_FSET;
    end else begin
      k = m4 ? idx - IDX_W'(1) : idx;
      case (k)
        IDX_W'(0), IDX_W'(1): begin
          s.code = {3'b001, ~m4, LINES2, FONT, 2'b00};
          s.gap  = GAP_FSET;
        end
        IDX_W'(2): begin
          s.code = {5'b00001, DISP_ON, CURSOR_ON, BLINK_ON};
          s.gap  = GAP_DISP;
        end
        IDX_W'(3): begin
          s.code = 8'b0000_0001;
          s.gap  = GAP_CLR;
        end
        default: begin
          s.code = {6'b000001, INCREMENT, SHIFT_ON};
          s.gap  = GAP_ENTRY;
        end
      endcase
    end
    return s;
  endfunction

  assign cur = stepAt(stepIdx, mode4Reg);

  always_comb begin
    unique case (cur.gap)
      GAP_FSET:  gapLoad = CNT_W'(FSET_CYC);
      GAP_DISP:  gapLoad = CNT_W'(DISP_CYC);
      GAP_CLR:   gapLoad = CNT_W'(CLR_CYC);
      default:   gapLoad = CNT_W'(ENTRY_CYC);
    endcase
  end

  // Strap capture: follows the pin only while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) mode4Reg <= mode4In;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepIdx  <= '0;
      lowPhase <= 1'b0;
      cnt      <= CNT_W'(PWR_CYC);
    end else begin
      if (strobe.loadGap) begin
        cnt      <= gapLoad;
        lowPhase <= 1'b0;
      end else if (cnt != '0) begin
        cnt <= cnt - CNT_W'(1);
      end
      if (strobe.nextNibble) lowPhase <= 1'b1;
      if (strobe.nextStep)   stepIdx  <= stepIdx + IDX_W'(1);
    end
  end

  assign delayZero = (cnt == '0);
  assign lastStep  = (stepIdx == (mode4Reg ? LAST4 : LAST8));
  assign needLow   = mode4Reg && !cur.single && !lowPhase;

  always_comb begin
    if (!mode4Reg)     xferData = cur.code;
    else if (lowPhase) xferData = {cur.code[3:0], 4'h0};
    else               xferData = {cur.code[7:4], 4'h0};
  end

endmodule

// File: rtl/lcd_init_ctrl.sv
module lcd_init_ctrl
  import lcd_init_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busAck,
  input  logic       delayZero,
  input  logic       lastStep,
  input  logic       needLow,
  output seqStrobe_t strobe,
  output logic       busReq,
  output logic       ready
);

  seqState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_POWER;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    busReq    = 1'b0;
    unique case (state)
      ST_POWER: begin
        if (delayZero) nextState = ST_REQ;
      end
      ST_REQ: begin
        busReq = 1'b1;
        if (busAck) begin
          if (needLow) begin
            strobe.nextNibble = 1'b1;
          end else begin
            strobe.loadGap = 1'b1;
            nextState      = ST_GAP;
          end
        end
      end
      ST_GAP: begin
        if (delayZero) begin
          if (lastStep) begin
            nextState = ST_DONE;
          end else begin
            strobe.nextStep = 1'b1;
            nextState       = ST_REQ;
          end
        end
      end
      default: ;
    endcase
  end

  assign ready = (state == ST_DONE);

endmodule

// File: rtl/lcd_init_seq.sv
module lcd_init_seq
  import lcd_init_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 100_000_000,
  parameter bit          LINES2    = 1'b1,
  parameter bit          FONT      = 1'b0,
  parameter bit          DISP_ON   = 1'b1,
  parameter bit          CURSOR_ON = 1'b0,
  parameter bit          BLINK_ON  = 1'b0,
  parameter bit          INCREMENT = 1'b1,
  parameter bit          SHIFT_ON  = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       mode4,
  input  logic       busAck,
  output logic       busReq,
  output logic [7:0] busData,
  output logic       ready
);

  seqStrobe_t strobe;
  logic       delayZero;
  logic       lastStep;
  logic       needLow;

  lcd_init_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busAck    (busAck),
    .delayZero (delayZero),
    .lastStep  (lastStep),
    .needLow   (needLow),
    .strobe    (strobe),
    .busReq    (busReq),
    .ready     (ready)
  );

  lcd_init_dp #(
    .CLK_HZ    (CLK_HZ),
    .LINES2    (LINES2),
    .FONT      (FONT),
    .DISP_ON   (DISP_ON),
    .CURSOR_ON (CURSOR_ON),
    .BLINK_ON  (BLINK_ON),
    .INCREMENT (INCREMENT),
    .SHIFT_ON  (SHIFT_ON)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .mode4In   (mode4),
    .strobe    (strobe),
    .delayZero (delayZero),
    .lastStep  (lastStep),
    .needLow   (needLow),
    .xferData  (busData)
  );

endmodule

// File: rtl/lcd_init_seq_chk.sv
module lcd_init_seq_chk
  import lcd_init_pkg::*;
#(
  parameter int unsigned CLK_HZ = 100_000_000
) (
  input logic       clk,
  input logic       rstN,
  input logic       mode4,
  input logic       busAck,
  input logic       busReq,
  input logic [7:0] busData,
  input logic       ready
);

  localparam int unsigned PWR_CYC = usToCycles(US_POWER, CLK_HZ);

  logic [31:0] sinceRst;
  logic        m4Seen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceRst <= '0;
      m4Seen   <= mode4;
    end else if (sinceRst <= PWR_CYC) begin
      sinceRst <= sinceRst + 32'd1;
    end
  end

  // R1: no request inside the power-up window
  a_r1_power_quiet: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> (sinceRst > PWR_CYC));

  // R2: pending request and data held until accepted
  a_r2_hold_req: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck) |=> (busReq && $stable(busData)));

  // R4: low data lines idle in 4-bit mode
  a_r4_low_lines_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && m4Seen) |-> (busData[3:0] == 4'h0));

  // R7: ready is sticky
  a_r7_ready_sticks: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> ready);

  // R7: nothing requested once ready
  a_r7_quiet_when_ready: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> !busReq);

endmodule

bind lcd_init_seq lcd_init_seq_chk #(.CLK_HZ(CLK_HZ)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .mode4   (mode4),
  .busAck  (busAck),
  .busReq  (busReq),
  .busData (busData),
  .ready   (ready)
);

// File: tb/lcd_init_seq_bench.sv
module lcd_init_seq_bench;

  localparam int unsigned TB_HZ  = 1_000_000;
  localparam int          MAXX   = 12;
  localparam int          SETTLE = 50;

  function automatic int toCyc(input int us);
    return (us * (TB_HZ / 1000) + 999) / 1000 + 1;  // ceil(us*hz/1e6)+1
  endfunction

  localparam int P_PWR  = (40000 * 1) + 1;  // at 1 MHz parameter
  int gF, gD, gC, gE;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       mode4 = 1'b0;
  logic       busAck = 1'b0;
  logic       busReq;
  logic [7:0] busData;
  logic       ready;

  int nVec = 0;
  int nBad = 0;
  int cyc  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lcd_init_seq #(
    .CLK_HZ    (TB_HZ),
    .LINES2    (1'b1),
    .FONT      (1'b0),
    .DISP_ON   (1'b1),
    .CURSOR_ON (1'b1),
    .BLINK_ON  (1'b0),
    .INCREMENT (1'b1),
    .SHIFT_ON  (1'b0)
  ) u_lcd_init_seq (
    .clk     (clk),
    .rstN    (rstN),
    .mode4   (mode4),
    .busAck  (busAck),
    .busReq  (busReq),
    .busData (busData),
    .ready   (ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  logic [7:0] expD[MAXX];
  int         expGap[MAXX];
  int         expN;

  task automatic setExpect(input bit m4);
    if (!m4) begin
      expN = 5;
      expD[0] = 8'h38; expGap[0] = gF + 1;
      expD[1] = 8'h38; expGap[1] = gF + 1;
      expD[2] = 8'h0E; expGap[2] = gD + 1;
      expD[3] = 8'h01; expGap[3] = gC + 1;
      expD[4] = 8'h06; expGap[4] = gE + 1;
    end else begin
      expN = 11;
      expD[0]  = 8'h20; expGap[0]  = gF + 1;
      expD[1]  = 8'h20; expGap[1]  = 0;
      expD[2]  = 8'h80; expGap[2]  = gF + 1;
      expD[3]  = 8'h20; expGap[3]  = 0;
      expD[4]  = 8'h80; expGap[4]  = gF + 1;
      expD[5]  = 8'h00; expGap[5]  = 0;
      expD[6]  = 8'hE0; expGap[6]  = gD + 1;
      expD[7]  = 8'h00; expGap[7]  = 0;
      expD[8]  = 8'h10; expGap[8]  = gC + 1;
      expD[9]  = 8'h00; expGap[9]  = 0;
      expD[10] = 8'h60; expGap[10] = gE + 1;
    end
  endtask

  // Runs one full start-up with a given strap, ack latency and strap disturbance
  task automatic runSeq(input bit m4, input int lat, input bit flip, input string tag);
    int         riseC[MAXX];
    int         doneC[MAXX];
    logic [7:0] gotD[MAXX];
    bit         held[MAXX];
    logic [7:0] firstD;
    int         nX, waitCnt, relCyc, readyCyc, after;
    bit         awaiting, extra, readyDrop;
    setExpect(m4);
    mode4  = m4;
    busAck = 1'b0;
    rstN   = 1'b0;
    repeat (4) @(negedge clk);
    chk(busReq == 1'b0, "R9 busReq in reset", int'(busReq), 0);
    chk(ready == 1'b0, "R9 ready in reset", int'(ready), 0);
    rstN = 1'b1;
    relCyc = cyc;
    nX = 0; waitCnt = 0; awaiting = 1'b1; extra = 1'b0; readyDrop = 1'b0;
    readyCyc = -1; after = 0; firstD = '0;
    for (int i = 0; i < MAXX; i++) begin riseC[i] = 0; doneC[i] = 0; gotD[i] = '0; held[i] = 1'b0; end
    while (after < SETTLE && (cyc - relCyc) < 60000) begin
      @(negedge clk);
      if (flip && (cyc - relCyc) == 100) mode4 = ~m4;
      if (busAck) begin
        busAck = 1'b0; waitCnt = 0; awaiting = 1'b1;
      end
      if (busReq) begin
        if (readyCyc >= 0 || nX >= MAXX) extra = 1'b1;
        else begin
          if (awaiting) begin riseC[nX] = cyc; firstD = busData; awaiting = 1'b0; end
          if (waitCnt == lat) begin
            gotD[nX] = busData; held[nX] = (busData == firstD);
            doneC[nX] = cyc + 1; nX++; busAck = 1'b1;
          end else waitCnt++;
        end
      end
      if (readyCyc >= 0) begin
        after++;
        if (!ready) readyDrop = 1'b1;
      end else if (ready) readyCyc = cyc;
    end
    mode4 = m4;
    chk(nX == expN, {tag, " R3/R4 transfer count"}, nX, expN);
    chk(riseC[0] - relCyc == P_PWR + 1, {tag, " R1 first request delay"}, riseC[0] - relCyc, P_PWR + 1);
    for (int i = 0; i < expN && i < nX; i++) begin
      chk(gotD[i] == expD[i], m4 ? {tag, " R4 nibble data"} : {tag, " R3 byte data"},
          int'(gotD[i]), int'(expD[i]));
      chk(held[i], {tag, " R2 data held until ack"}, int'(held[i]), 1);
      if (i + 1 < nX)
        chk(riseC[i+1] - doneC[i] == expGap[i],
            (expGap[i] == 0) ? {tag, " R5 low nibble follows"} : {tag, " R6 gap"},
            riseC[i+1] - doneC[i], expGap[i]);
    end
    if (nX == expN)
      chk(readyCyc - doneC[expN-1] == expGap[expN-1], {tag, " R7 ready timing"},
          readyCyc - doneC[expN-1], expGap[expN-1]);
    else
      chk(1'b0, {tag, " R7 ready timing"}, readyCyc, -1);
    chk(!extra, {tag, " R7 no request after ready"}, int'(extra), 0);
    chk(!readyDrop, {tag, " R7 ready stays high"}, int'(readyDrop), 0);
  endtask

  task automatic testEightBit();      runSeq(1'b0, 0, 1'b0, "8bit");   endtask
  task automatic testFourBit();       runSeq(1'b1, 3, 1'b0, "4bit");   endtask
  task automatic testStrapIgnored();  runSeq(1'b0, 1, 1'b1, "R8 strap"); endtask

  initial begin
    gF = toCyc(39); gD = toCyc(37); gC = toCyc(1530); gE = toCyc(39);
    testEightBit();
    testFourBit();
    testStrapIgnored();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nVec++; nBad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

endmodule